// File: doc/BRIEF.md
# Switch Packet Routing Decision Engine

This block sits behind the ingress side of a multi-port switch and decides the fate of each transaction-layer request or completion header. Port 0 is the upstream (primary) port and ports 1 to NUM_DN face downstream. From the header format and type fields, the routing subfield of messages, the target address or target ID, the ingress port index and the programmed windows of every downstream port, the engine makes one of four decisions. It can consume the packet locally, send it to one or more egress ports, report an unsupported request, or flag the header as malformed.

Three routing methods are combined. Address routing compares against the switch's own BAR result and then against the memory or IO windows of the downstream ports. ID routing compares against the switch's own bus/device/function number and then against the secondary-to-subordinate bus ranges. Implicit routing for messages depends on the direction the packet travelled. The decision is registered and offered on a valid/ready output, one clock after the header is taken.

Top module: `tlp_route_engine`

## Requirements
- R1: The format field `hdr_fmt` (bit 0 set means 4-dword header, bit 1 set means data present) and the type field `hdr_type` are checked together. Type 00000 (memory) takes any format. Type 00001 (locked memory read) requires no data. Types 00010 (IO), 00100 and 00101 (config) and 01010 and 01011 (completions) require a 3-dword header. Type 10rrr (message) requires a 4-dword header. Every other combination is flagged malformed.
- R2: For a message, the low three type bits select the routing. 000 means toward the root and 101 means gather toward the root. 001 selects address routing and 010 selects ID routing. 011 means broadcast from the root and 100 means terminate at the receiver. 110 and 111 are flagged malformed.
- R3: An address-routed packet is consumed whenever `bar_hit` is set, before any window is looked at.
- R4: Memory windows: the address is `hdr_dw2` for a 3-dword header and {`hdr_dw2`,`hdr_dw3`} for a 4-dword header. Downstream port p matches when the upper 32 bits are zero and base·2^20 ≤ address ≤ limit·2^20 + 0xFFFFF, using its 12-bit base and limit fields. The matching port with the lowest index receives the packet.
- R5: IO windows: port p matches when address bits 31:16 are zero and base·2^12 ≤ address ≤ limit·2^12 + 0xFFF, using its 4-bit base and limit fields. The lowest matching index wins.
- R6: An ID-routed packet carries its target ID in `hdr_dw2[31:16]`, with the bus number in bits 31:24. It is consumed when the ID equals `own_id`. Otherwise it goes to the lowest-index port whose secondary ≤ bus ≤ subordinate.
- R7: An address- or ID-routed packet with no match is reported as an unsupported request if it came in on port 0. If it came in on a downstream port, it goes to port 0.
- R8: A broadcast message from port 0 goes to every downstream port at once. From a downstream port it is flagged malformed.
- R9: A toward-root or gather message from a downstream port goes to port 0. From port 0 it is reported as an unsupported request.
- R10: A terminate-at-receiver message is consumed whatever its ingress port.
- R11: A header is taken when `hdr_valid` and `hdr_ready` are both high. Its decision appears with `dec_valid` on the next clock, with exactly one outcome set. The decision is held unchanged while `dec_ready` is low. `hdr_ready` equals not `dec_valid` or `dec_ready`. Bit p of `dec_egress` stands for port p.
- R12: While reset is asserted, `dec_valid` is low and `hdr_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hdr_valid | input | 1 | Header present |
| hdr_ready | output | 1 | Engine can take a header |
| hdr_fmt | input | 2 | Header format field |
| hdr_type | input | 5 | Header type field |
| hdr_dw2 | input | 32 | Third header dword (address, or target ID) |
| hdr_dw3 | input | 32 | Fourth header dword (low address for 4-dword headers) |
| in_port | input | PORT_W | Ingress port index, 0 is upstream |
| bar_hit | input | 1 | The switch's own BAR decode claims the address |
| own_id | input | 16 | Switch bus/device/function number |
| mem_base | input | 12·NUM_DN | Memory window base, address bits 31:20, port p at slice p-1 |
| mem_limit | input | 12·NUM_DN | Memory window limit, address bits 31:20 |
| io_base | input | 4·NUM_DN | IO window base, address bits 15:12 |
| io_limit | input | 4·NUM_DN | IO window limit, address bits 15:12 |
| sec_bus | input | 8·NUM_DN | Secondary bus number per downstream port |
| sub_bus | input | 8·NUM_DN | Subordinate bus number per downstream port |
| dec_valid | output | 1 | Decision present |
| dec_ready | input | 1 | Decision taken by the consumer |
| dec_egress | output | NUM_DN+1 | Egress port mask |
| dec_consume | output | 1 | Packet consumed locally |
| dec_ur | output | 1 | Unsupported request |
| dec_malformed | output | 1 | Malformed header |

## Verification
The bench builds the engine with NUM_DN = 3. This gives a two-bit ingress index in which every value names a real port. With only three ports, overlapping memory windows, a disabled IO window (base above limit) and a peer-to-peer ID route between downstream ports can all be set up with a handful of register values. The window edges land on exact 2^20 and 2^12 boundaries. A random phase then mixes legal and illegal format/type codes with single-cycle stalls on `dec_ready`.

// File: rtl/tlp_route_pkg.sv
package tlp_route_pkg;

    // Routing class of a decoded header
    typedef enum logic [2:0] {
        K_MEM     = 3'd0,
        K_IO      = 3'd1,
        K_ID      = 3'd2,
        K_TO_ROOT = 3'd3,
        K_BCAST   = 3'd4,
        K_LOCAL   = 3'd5,
        K_BAD     = 3'd6
    } route_kind_e;

    localparam int MEM_FLD_W = 12;  // memory window field, address bits 31:20
    localparam int IO_FLD_W  = 4;   // IO window field, address bits 15:12
    localparam int BUS_W     = 8;
    localparam int ID_W      = 16;

    function automatic logic mem_window_hit(
        input logic [31:0]          hi,
        input logic [31:0]          lo,
        input logic [MEM_FLD_W-1:0] base,
        input logic [MEM_FLD_W-1:0] lim
    );
        return (hi == 32'h0) &&
               (lo >= {base, 20'h00000}) &&
               (lo <= {lim, 20'hFFFFF});
    endfunction

    function automatic logic io_window_hit(
        input logic [31:0]         hi,
        input logic [31:0]         lo,
        input logic [IO_FLD_W-1:0] base,
        input logic [IO_FLD_W-1:0] lim
    );
        return (hi == 32'h0) && (lo[31:16] == 16'h0) &&
               (lo[15:0] >= {base, 12'h000}) &&
               (lo[15:0] <= {lim, 12'hFFF});
    endfunction

    function automatic logic bus_range_hit(
        input logic [BUS_W-1:0] bus,
        input logic [BUS_W-1:0] sec,
        input logic [BUS_W-1:0] sub
    );
        return (bus >= sec) && (bus <= sub);
    endfunction

endpackage

// File: rtl/tlp_hdr_decode.sv
module tlp_hdr_decode
    import tlp_route_pkg::*;
(
    input  logic [1:0]  fmt,
    input  logic [4:0]  typ,
    input  logic [31:0] dw2,
    input  logic [31:0] dw3,
    output route_kind_e kind,
    output logic [31:0] addr_hi,
    output logic [31:0] addr_lo,
    output logic [15:0] tgt_id
);

    logic four_dw;
    logic has_data;

    assign four_dw  = fmt[0];
    assign has_data = fmt[1];

    always_comb begin
        kind = K_BAD;
        casez (typ)
            5'b00000: kind = K_MEM;
            5'b00001: kind = has_data ? K_BAD : K_MEM;
            5'b00010: kind = four_dw ? K_BAD : K_IO;
            5'b0010?: kind = four_dw ? K_BAD : K_ID;
            5'b0101?: kind = four_dw ? K_BAD : K_ID;
            5'b10???: begin
                if (!four_dw) begin
                    kind = K_BAD;
                end else begin
                    case (typ[2:0])
                        3'b000:  kind = K_TO_ROOT;
                        3'b001:  kind = K_MEM;
                        3'b010:  kind = K_ID;
                        3'b011:  kind = K_BCAST;
                        3'b100:  kind = K_LOCAL;
                        3'b101:  kind = K_TO_ROOT;
                        default: kind = K_BAD;
                    endcase
                end
            end
            default: kind = K_BAD;
        endcase
    end

    // Address layout: 3-dword headers carry a 32-bit address in dw2,
    // 4-dword headers carry the upper half in dw2 and the lower in dw3.
    always_comb begin
        if (four_dw) begin
            addr_hi = dw2;
            addr_lo = dw3;
        end else begin
            addr_hi = 32'h0;
            addr_lo = dw2;
        end
    end

    assign tgt_id = dw2[31:16];

endmodule

// File: rtl/tlp_window_match.sv
module tlp_window_match
    import tlp_route_pkg::*;
#(
    parameter int NUM_DN = 4
) (
    input  route_kind_e                  kind,
    input  logic [31:0]                  addr_hi,
    input  logic [31:0]                  addr_lo,
    input  logic [BUS_W-1:0]             tgt_bus,
    input  logic [NUM_DN*MEM_FLD_W-1:0]  mem_base,
    input  logic [NUM_DN*MEM_FLD_W-1:0]  mem_limit,
    input  logic [NUM_DN*IO_FLD_W-1:0]   io_base,
    input  logic [NUM_DN*IO_FLD_W-1:0]   io_limit,
    input  logic [NUM_DN*BUS_W-1:0]      sec_bus,
    input  logic [NUM_DN*BUS_W-1:0]      sub_bus,
    output logic                         hit,
    output logic [NUM_DN-1:0]            hit_mask
);

    logic [NUM_DN-1:0] raw_hit;
    logic              taken;

    for (genvar i = 0; i < NUM_DN; i++) begin : g_dn
        always_comb begin
            case (kind)
                K_MEM: raw_hit[i] = mem_window_hit(addr_hi, addr_lo,
                                        mem_base[i*MEM_FLD_W +: MEM_FLD_W],
                                        mem_limit[i*MEM_FLD_W +: MEM_FLD_W]);
                K_IO:  raw_hit[i] = io_window_hit(addr_hi, addr_lo,
                                        io_base[i*IO_FLD_W +: IO_FLD_W],
                                        io_limit[i*IO_FLD_W +: IO_FLD_W]);
                K_ID:  raw_hit[i] = bus_range_hit(tgt_bus,
                                        sec_bus[i*BUS_W +: BUS_W],
                                        sub_bus[i*BUS_W +: BUS_W]);
                default: raw_hit[i] = 1'b0;
            endcase
        end
    end

    // Lowest-index match wins when windows overlap
    always_comb begin
        hit_mask = '0;
        taken    = 1'b0;
        for (int i = 0; i < NUM_DN; i++) begin
            if (raw_hit[i] && !taken) begin
                hit_mask[i] = 1'b1;
                taken       = 1'b1;
            end
        end
    end

    assign hit = |raw_hit;

endmodule

// File: rtl/tlp_route_engine.sv
module tlp_route_engine
    import tlp_route_pkg::*;
#(
    parameter  int NUM_DN    = 4,
    localparam int NUM_PORTS = NUM_DN + 1,
    localparam int PORT_W    = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          hdr_valid,
    output logic                          hdr_ready,
    input  logic [1:0]                    hdr_fmt,
    input  logic [4:0]                    hdr_type,
    input  logic [31:0]                   hdr_dw2,
    input  logic [31:0]                   hdr_dw3,
    input  logic [PORT_W-1:0]             in_port,
    input  logic                          bar_hit,
    input  logic [ID_W-1:0]               own_id,
    input  logic [NUM_DN*MEM_FLD_W-1:0]   mem_base,
    input  logic [NUM_DN*MEM_FLD_W-1:0]   mem_limit,
    input  logic [NUM_DN*IO_FLD_W-1:0]    io_base,
    input  logic [NUM_DN*IO_FLD_W-1:0]    io_limit,
    input  logic [NUM_DN*BUS_W-1:0]       sec_bus,
    input  logic [NUM_DN*BUS_W-1:0]       sub_bus,
    output logic                          dec_valid,
    input  logic                          dec_ready,
    output logic [NUM_PORTS-1:0]          dec_egress,
    output logic                          dec_consume,
    output logic                          dec_ur,
    output logic                          dec_malformed
);

    typedef struct packed {
        logic                 valid;
        logic [NUM_PORTS-1:0] egress;
        logic                 consume;
        logic                 ur;
        logic                 mal;
    } dec_t;

    localparam logic [NUM_PORTS-1:0] UP_MASK    = NUM_PORTS'(1);
    localparam logic [NUM_PORTS-1:0] DOWN_MASK  = ~UP_MASK;

    route_kind_e       kind;
    logic [31:0]       addr_hi;
    logic [31:0]       addr_lo;
    logic [ID_W-1:0]   tgt_id;
    logic              win_hit;
    logic [NUM_DN-1:0] win_mask;
    logic              accept;
    logic              from_up;

    dec_t st_d;
    dec_t st_q;

    tlp_hdr_decode u_decode (
        .fmt     (hdr_fmt),
        .typ     (hdr_type),
        .dw2     (hdr_dw2),
        .dw3     (hdr_dw3),
        .kind    (kind),
        .addr_hi (addr_hi),
        .addr_lo (addr_lo),
        .tgt_id  (tgt_id)
    );

    tlp_window_match #(.NUM_DN(NUM_DN)) u_windows (
        .kind      (kind),
        .addr_hi   (addr_hi),
        .addr_lo   (addr_lo),
        .tgt_bus   (tgt_id[ID_W-1 -: BUS_W]),
        .mem_base  (mem_base),
        .mem_limit (mem_limit),
        .io_base   (io_base),
        .io_limit  (io_limit),
        .sec_bus   (sec_bus),
        .sub_bus   (sub_bus),
        .hit       (win_hit),
        .hit_mask  (win_mask)
    );

    assign hdr_ready = !st_q.valid || dec_ready;
    assign accept    = hdr_valid && hdr_ready;
    assign from_up   = (in_port == '0);

    // Outcome for a packet that matched nothing local or downstream
    function automatic dec_t miss_outcome(input logic up);
        dec_t r;
        r       = '0;
        r.valid = 1'b1;
        if (up) r.ur     = 1'b1;
        else    r.egress = UP_MASK;
        return r;
    endfunction

    always_comb begin
        st_d = st_q;
        if (accept) begin
            st_d       = '0;
            st_d.valid = 1'b1;
            case (kind)
                K_MEM, K_IO: begin
                    if (bar_hit)      st_d.consume = 1'b1;
                    else if (win_hit) st_d.egress  = {win_mask, 1'b0};
                    else              st_d         = miss_outcome(from_up);
                end
                K_ID: begin
                    if (tgt_id == own_id) st_d.consume = 1'b1;
                    else if (win_hit)     st_d.egress  = {win_mask, 1'b0};
                    else                  st_d         = miss_outcome(from_up);
                end
                K_TO_ROOT: begin
                    if (from_up) st_d.ur     = 1'b1;
                    else         st_d.egress = UP_MASK;
                end
                K_BCAST: begin
                    if (from_up) st_d.egress = DOWN_MASK;
                    else         st_d.mal    = 1'b1;
                end
                K_LOCAL: st_d.consume = 1'b1;
                default: st_d.mal     = 1'b1;
            endcase
        end else if (dec_ready) begin
            st_d.valid = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dec_valid     = st_q.valid;
    assign dec_egress    = st_q.egress;
    assign dec_consume   = st_q.consume;
    assign dec_ur        = st_q.ur;
    assign dec_malformed = st_q.mal;

endmodule

// File: rtl/tlp_route_engine_chk.sv
module tlp_route_engine_chk #(
    parameter  int NUM_DN    = 4,
    localparam int NUM_PORTS = NUM_DN + 1,
    localparam int PORT_W    = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 hdr_valid,
    input logic                 hdr_ready,
    input logic [PORT_W-1:0]    in_port,
    input logic                 dec_valid,
    input logic                 dec_ready,
    input logic [NUM_PORTS-1:0] dec_egress,
    input logic                 dec_consume,
    input logic                 dec_ur,
    input logic                 dec_malformed
);

    a_r11_single_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |-> $countones({|dec_egress, dec_consume, dec_ur, dec_malformed}) == 1);

    a_r11_take_to_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_valid && hdr_ready) |=> dec_valid);

    a_r11_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && !dec_ready) |=> (dec_valid && $stable(dec_egress) &&
            $stable(dec_consume) && $stable(dec_ur) && $stable(dec_malformed)));

    a_r7_up_never_back_up: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_valid && hdr_ready && in_port == '0) |=> !dec_egress[0]);

    a_r7_down_never_ur: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_valid && hdr_ready && in_port != '0) |=> !dec_ur);

    a_r8_multicast_is_all_down: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && $countones(dec_egress) > 1) |->
            (!dec_egress[0] && (&dec_egress[NUM_PORTS-1:1])));

    a_r12_reset_idle: assert property (@(posedge clk)
        !rst_n |=> !dec_valid);

endmodule

bind tlp_route_engine tlp_route_engine_chk #(.NUM_DN(NUM_DN)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .hdr_valid     (hdr_valid),
    .hdr_ready     (hdr_ready),
    .in_port       (in_port),
    .dec_valid     (dec_valid),
    .dec_ready     (dec_ready),
    .dec_egress    (dec_egress),
    .dec_consume   (dec_consume),
    .dec_ur        (dec_ur),
    .dec_malformed (dec_malformed)
);

// File: tb/tlp_route_engine_tb_top.sv
module tlp_route_engine_tb_top;

    localparam int ND = 3;
    localparam int NP = ND + 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hdr_valid = 1'b0;
    logic        hdr_ready;
    logic [1:0]  hdr_fmt = 2'b00;
    logic [4:0]  hdr_type = 5'b0;
    logic [31:0] hdr_dw2 = 32'h0;
    logic [31:0] hdr_dw3 = 32'h0;
    logic [1:0]  in_port = 2'd0;
    logic        bar_hit = 1'b0;
    logic [15:0] own_id = 16'h0100;
    logic [ND*12-1:0] mem_base, mem_limit;
    logic [ND*4-1:0]  io_base, io_limit;
    logic [ND*8-1:0]  sec_bus, sub_bus;
    logic        dec_valid;
    logic        dec_ready = 1'b1;
    logic [NP-1:0] dec_egress;
    logic        dec_consume, dec_ur, dec_malformed;

    // Programmed windows, indexed by downstream port 1..3
    int mb [1:ND] = '{32'h100, 32'h200, 32'h180};
    int ml [1:ND] = '{32'h1FF, 32'h2FF, 32'h300};
    int ib [1:ND] = '{1, 2, 15};
    int il [1:ND] = '{1, 3, 0};
    int sb [1:ND] = '{2, 5, 6};
    int ub [1:ND] = '{4, 5, 9};

    always #5 clk = ~clk;

    always_comb begin
        for (int p = 1; p <= ND; p++) begin
            mem_base [(p-1)*12 +: 12] = mb[p][11:0];
            mem_limit[(p-1)*12 +: 12] = ml[p][11:0];
            io_base  [(p-1)*4 +: 4]   = ib[p][3:0];
            io_limit [(p-1)*4 +: 4]   = il[p][3:0];
            sec_bus  [(p-1)*8 +: 8]   = sb[p][7:0];
            sub_bus  [(p-1)*8 +: 8]   = ub[p][7:0];
        end
    end

    tlp_route_engine #(.NUM_DN(ND)) dut_i (
        .clk, .rst_n, .hdr_valid, .hdr_ready, .hdr_fmt, .hdr_type,
        .hdr_dw2, .hdr_dw3, .in_port, .bar_hit, .own_id,
        .mem_base, .mem_limit, .io_base, .io_limit, .sec_bus, .sub_bus,
        .dec_valid, .dec_ready, .dec_egress, .dec_consume, .dec_ur,
        .dec_malformed
    );

    int total = 0;
    int bad = 0;

    // Reference model state
    bit       exp_valid = 0;
    bit [3:0] exp_eg = 0;
    bit       exp_cons = 0, exp_ur = 0, exp_mal = 0;
    string    exp_req = "R12";
    bit       took = 0;

    function automatic void ref_route(
        input bit [1:0] f, input bit [4:0] t, input bit [31:0] d2, input bit [31:0] d3,
        input int port, input bit bar,
        output bit [3:0] eg, output bit cons, output bit ur, output bit mal,
        output string req);
        bit [63:0] addr;
        int method;   // 0 mem, 1 io, 2 id, 3 root, 4 bcast, 5 local, 6 bad
        int hitp;
        int bus;
        eg = 0; cons = 0; ur = 0; mal = 0; hitp = 0;
        addr = f[0] ? {d2, d3} : {32'h0, d2};
        bus  = int'(d2[31:24]);
        method = 6;
        if (t == 5'd0) method = 0;
        else if (t == 5'd1 && !f[1]) method = 0;
        else if (t == 5'd2 && !f[0]) method = 1;
        else if ((t == 5'd4 || t == 5'd5 || t == 5'd10 || t == 5'd11) && !f[0]) method = 2;
        else if (t[4:3] == 2'b10 && f[0]) begin
            if (t[2:0] == 0 || t[2:0] == 5) method = 3;
            else if (t[2:0] == 1) method = 0;
            else if (t[2:0] == 2) method = 2;
            else if (t[2:0] == 3) method = 4;
            else if (t[2:0] == 4) method = 5;
            else begin method = 6; req = "R2"; end
        end
        if (method == 6) begin
            mal = 1;
            if (!(t[4:3] == 2'b10 && f[0])) req = "R1";
            return;
        end
        if (method == 5) begin cons = 1; req = "R10"; return; end
        if (method == 4) begin
            req = "R8";
            if (port == 0) eg = 4'b1110; else mal = 1;
            return;
        end
        if (method == 3) begin
            req = "R9";
            if (port == 0) ur = 1; else eg = 4'b0001;
            return;
        end
        if (method == 2 && d2[31:16] == own_id) begin cons = 1; req = "R6"; return; end
        if (method != 2 && bar) begin cons = 1; req = "R3"; return; end
        for (int p = 1; p <= ND; p++) begin
            bit in_win;
            if (method == 0)
                in_win = addr >= (64'(mb[p]) << 20) && addr <= ((64'(ml[p]) << 20) + 64'hFFFFF);
            else if (method == 1)
                in_win = addr >= (64'(ib[p]) << 12) && addr <= ((64'(il[p]) << 12) + 64'hFFF);
            else
                in_win = bus >= sb[p] && bus <= ub[p];
            if (in_win && hitp == 0) hitp = p;
        end
        req = (method == 0) ? "R4" : (method == 1) ? "R5" : "R6";
        if (hitp != 0) begin eg[hitp] = 1'b1; return; end
        req = "R7";
        if (port == 0) ur = 1; else eg = 4'b0001;
    endfunction

    // Model advances on every clock edge
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            exp_valid = 0;
        end else if (hdr_valid && (!exp_valid || dec_ready)) begin
            ref_route(hdr_fmt, hdr_type, hdr_dw2, hdr_dw3, int'(in_port), bar_hit,
                      exp_eg, exp_cons, exp_ur, exp_mal, exp_req);
            exp_valid = 1;
            took = 1;
        end else if (dec_ready) begin
            exp_valid = 0;
        end
    end

    // Compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            total++;
            if (hdr_ready !== (!exp_valid || dec_ready)) begin
                bad++;
                $display("FAIL R11 hdr_ready actual=%b expected=%b", hdr_ready, !exp_valid || dec_ready);
            end
            total++;
            if (dec_valid !== exp_valid) begin
                bad++;
                $display("FAIL R11 dec_valid actual=%b expected=%b", dec_valid, exp_valid);
            end else if (exp_valid) begin
                total++;
                if (dec_egress !== exp_eg || dec_consume !== exp_cons ||
                    dec_ur !== exp_ur || dec_malformed !== exp_mal) begin
                    bad++;
                    $display("FAIL %s actual=eg%b c%b u%b m%b expected=eg%b c%b u%b m%b",
                             exp_req, dec_egress, dec_consume, dec_ur, dec_malformed,
                             exp_eg, exp_cons, exp_ur, exp_mal);
                end
            end
        end
    end

    task automatic send(input bit [1:0] f, input bit [4:0] t, input bit [31:0] d2,
                        input bit [31:0] d3, input int port, input bit bar);
        @(negedge clk);
        hdr_fmt = f; hdr_type = t; hdr_dw2 = d2; hdr_dw3 = d3;
        in_port = port[1:0]; bar_hit = bar;
        took = 0;
        hdr_valid = 1;
        do begin
            @(negedge clk);
            if (!took) dec_ready = 1;
        end while (!took);
        hdr_valid = 0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL R11 watchdog actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        repeat (2) @(negedge clk);
        // R12: outputs while reset is held
        total++;
        if (dec_valid !== 1'b0 || hdr_ready !== 1'b1) begin
            bad++;
            $display("FAIL R12 reset actual=v%b r%b expected=v0 r1", dec_valid, hdr_ready);
        end
        rst_n = 1;

        // R3 own BAR claims first
        send(2'b00, 5'd0, 32'h1800_0000, 0, 0, 1);
        // R4 overlap priority, 4-dword form, boundaries
        send(2'b00, 5'd0, 32'h1800_0000, 0, 0, 0);
        send(2'b11, 5'd0, 32'h0, 32'h2800_0000, 0, 0);
        send(2'b11, 5'd0, 32'h1, 32'h2800_0000, 0, 0);       // R7 upper bits set
        send(2'b10, 5'd0, 32'h1FFF_FFFC, 0, 1, 0);
        send(2'b10, 5'd0, 32'h2000_0000, 0, 1, 0);
        send(2'b00, 5'd0, 32'h0FFF_FFFC, 0, 2, 0);           // R7 upstream
        send(2'b00, 5'd0, 32'h3000_0000, 0, 0, 0);
        send(2'b00, 5'd0, 32'h3010_0000, 0, 0, 0);           // R7 UR
        // R5 IO windows
        send(2'b00, 5'd2, 32'h0000_1FFC, 0, 0, 0);
        send(2'b10, 5'd2, 32'h0000_3FFC, 0, 0, 0);
        send(2'b00, 5'd2, 32'h0000_4000, 0, 1, 0);
        send(2'b00, 5'd2, 32'h1000_2000, 0, 0, 0);
        // R6 ID routing
        send(2'b00, 5'd5, 32'h0308_0000, 0, 0, 0);
        send(2'b10, 5'd4, 32'h0100_0000, 0, 0, 0);
        send(2'b00, 5'd5, 32'h0500_0000, 0, 0, 0);
        send(2'b10, 5'd10, 32'h0900_0000, 0, 2, 0);
        send(2'b00, 5'd5, 32'h0A00_0000, 0, 0, 0);
        send(2'b00, 5'd10, 32'h2000_0000, 0, 2, 0);
        send(2'b10, 5'd11, 32'h0600_0000, 0, 1, 0);
        // R1 illegal combinations
        send(2'b01, 5'd2, 32'h0, 0, 0, 0);
        send(2'b10, 5'd1, 32'h1800_0000, 0, 0, 0);
        send(2'b00, 5'd3, 32'h0, 0, 0, 1);
        send(2'b01, 5'd4, 32'h0100_0000, 0, 0, 0);
        send(2'b00, 5'b10100, 32'h0, 0, 0, 0);
        // R2 message routing codes
        send(2'b01, 5'b10110, 32'h0, 0, 1, 0);
        send(2'b11, 5'b10111, 32'h0, 0, 0, 0);
        send(2'b01, 5'b10001, 32'h0, 32'h2000_0000, 0, 0);
        send(2'b11, 5'b10010, 32'h0500_0000, 0, 3, 0);
        // R8 broadcast
        send(2'b01, 5'b10011, 32'h0, 0, 0, 0);
        send(2'b01, 5'b10011, 32'h0, 0, 2, 0);
        // R9 toward root and gather
        send(2'b01, 5'b10000, 32'h0, 0, 3, 0);
        send(2'b01, 5'b10000, 32'h0, 0, 0, 0);
        send(2'b11, 5'b10101, 32'h0, 0, 1, 0);
        send(2'b01, 5'b10101, 32'h0, 0, 0, 0);
        // R10 terminate locally
        send(2'b01, 5'b10100, 32'h0, 0, 0, 0);
        send(2'b11, 5'b10100, 32'h0, 0, 2, 0);

        // R11 stall: decision held while dec_ready is low
        @(negedge clk);
        dec_ready = 0;
        send(2'b00, 5'd0, 32'h2000_0000, 0, 0, 0);
        hdr_fmt = 2'b01; hdr_type = 5'b10011; in_port = 2'd0; took = 0;
        dec_ready = 0;
        hdr_valid = 1;
        repeat (4) @(negedge clk);
        dec_ready = 1;
        do @(negedge clk); while (!took);
        hdr_valid = 0;

        // Random mix with occasional one-cycle stalls
        for (int n = 0; n < 300; n++) begin
            bit [4:0]  t;
            bit [31:0] d2, d3;
            case ($urandom % 10)
                0: t = 5'd0;  1: t = 5'd1;  2: t = 5'd2;  3: t = 5'd4;
                4: t = 5'd5;  5: t = 5'd10; 6: t = 5'd11;
                7: t = 5'b10000 | 5'($urandom % 8);
                8: t = 5'($urandom);
                default: t = 5'b10000 | 5'($urandom % 6);
            endcase
            case ($urandom % 4)
                0: d2 = {8'($urandom % 12), 24'($urandom)};
                1: d2 = $urandom & 32'h0000_FFFC;
                2: d2 = 32'h0;
                default: d2 = (32'($urandom % 5) << 28) | ($urandom & 32'h0FFF_FFFC);
            endcase
            d3 = (32'($urandom % 5) << 28) | ($urandom & 32'h0FFF_FFFC);
            @(negedge clk);
            dec_ready = ($urandom % 4) != 0;
            send(2'($urandom), t, d2, d3, int'($urandom % 4), 1'($urandom % 5 == 0));
        end

        repeat (3) @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule